// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block sits on the programmer side of a link to a microcontroller that accepts in-system programming over a four-wire SPI port. It owns the target's reset line, serial clock, data-out and data-in pins and runs entirely from the system clock. A host issues one request at a time through a small command interface. The block turns each request into the right 32-bit serial instruction and times the reset pulse, the start-up settle time and the fixed write delays.

A start request holds SCK low and pulses the target's reset line high. It then waits a settle time and sends the programming-enable instruction. The instruction counts as accepted only when the byte clocked in during the third byte equals the key sent as the second byte. On a mismatch the block pulses reset, waits again and retries, up to a bounded number of attempts. Once programming is enabled, the host can fill the flash page buffer one byte at a time, commit a page, write EEPROM bytes and read back either memory. After a commit or an EEPROM write the block stays busy for a fixed delay instead of polling the target.

Top module: `serprog_host`

## Requirements
- R1: After reset, tgtReset and tgtSck are 0 and busy, enabled and errFlag are 0.
- R2: Command 0 (start) drives tgtReset high for at least RST_CLKS clocks while tgtSck is low, then drives it low and waits at least SETTLE_CLKS clocks before the first SCK rising edge.
- R3: Every instruction is 32 SCK periods, MSB first. Each SCK high phase lasts exactly SCK_HALF clocks, and each low phase lasts at least SCK_HALF clocks. tgtMosi changes only while SCK is low, and tgtMiso is captured at each SCK rising edge, after the falling edge on which the target drives it.
- R4: The enable instruction is the bytes 0xAC, 0x53, 0x00, 0x00, always sent in full. enabled is set only if the byte received during the third byte is 0x53.
- R5: On an echo mismatch the reset pulse, settle wait and enable instruction are repeated. After MAX_TRY failed attempts errFlag is 1, enabled is 0 and the block is idle.
- R6: Command 1 (page load) sends 0x40 (reqHigh=0) or 0x48 (reqHigh=1), then 0x00, then reqAddr[7:0] masked to its low PAGE_BITS bits, then reqData. No delay follows.
- R7: Command 2 (page commit) sends 0x4C, reqAddr[15:8], reqAddr[7:0] with the low PAGE_BITS bits cleared, then 0x00. busy then stays high with no SCK activity for at least FLASH_WAIT clocks.
- R8: Command 3 (EEPROM write) sends 0xC0, reqAddr[15:8], reqAddr[7:0], reqData. busy then stays high with no SCK activity for at least EE_WAIT clocks.
- R9: Command 4 (flash read) sends 0x20 (low byte) or 0x28 (high byte), and command 5 (EEPROM read) sends 0xA0. Each is followed by reqAddr[15:8], reqAddr[7:0] and 0x00. When the read completes, rdValid pulses for one clock and rdData holds the byte received during the fourth byte.
- R10: Commands 1 to 5 while enabled is 0, and command 7 at any time, are ignored: SCK does not toggle and busy stays 0.
- R11: Command 6 (release) drives tgtReset high and clears enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when busy is 0 |
| reqCmd | input | 3 | Command code (0 to 7, see R2 to R11) |
| reqAddr | input | 16 | Word address (flash) or byte address (EEPROM) |
| reqHigh | input | 1 | Selects the high byte of a flash word |
| reqData | input | 8 | Data byte for loads and EEPROM writes |
| busy | output | 1 | Sequence, instruction or write delay in progress |
| enabled | output | 1 | Target accepted the programming-enable instruction |
| errFlag | output | 1 | Enable retries exhausted |
| rdValid | output | 1 | One-clock pulse when a read completes |
| rdData | output | 8 | Last byte read from the target |
| tgtReset | output | 1 | Target reset line (high = reset pulse / release) |
| tgtSck | output | 1 | Serial clock to the target |
| tgtMosi | output | 1 | Serial data to the target |
| tgtMiso | input | 1 | Serial data from the target |

## Verification
A target model decodes every instruction, keeps a flash page buffer, a flash array and an EEPROM, and echoes the previous byte. It can be told to spoil the echo for a chosen number of enable attempts. The enable sequence is tried with three spoiled echoes, which must end in success after four reset pulses, and with more spoiled echoes than the retry limit, which must end in the error flag after exactly MAX_TRY pulses. A full page of 64 words with arithmetically distinct low and high bytes is loaded, committed with non-zero page-offset bits and read back word by word. Any swap of high and low opcodes, any wrong address mask or any MSB/LSB confusion shows up as a data mismatch, and an unwritten word that reads 0xFF shows the commit stayed inside its page. A run of EEPROM bytes, the busy length after writes, the SCK phase widths and the commands sent while programming is disabled cover the timing and ignore rules.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  localparam int WAIT_W = 32;

  typedef enum logic [2:0] {
    CMD_START   = 3'd0,
    CMD_LOAD    = 3'd1,
    CMD_COMMIT  = 3'd2,
    CMD_EEWR    = 3'd3,
    CMD_FRD     = 3'd4,
    CMD_EERD    = 3'd5,
    CMD_RELEASE = 3'd6,
    CMD_NONE    = 3'd7
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              frameGo;
    logic [31:0]       frame;
    logic              waitGo;
    logic [WAIT_W-1:0] waitLen;
    logic              rstHigh;
    logic              rstLow;
  } strobe_t;

  localparam logic [7:0] OP_ENABLE  = 8'hAC;
  localparam logic [7:0] ECHO_KEY   = 8'h53;
  localparam logic [7:0] OP_LOAD_LO = 8'h40;
  localparam logic [7:0] OP_LOAD_HI = 8'h48;
  localparam logic [7:0] OP_COMMIT  = 8'h4C;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;

endpackage

// File: rtl/serprog_dp.sv
module serprog_dp
  import serprog_pkg::*;
#(
  parameter int SCK_HALF = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     ctl,
  output logic        frameDone,
  output logic [15:0] rxLow,
  output logic        timerZero,
  output logic        tgtReset,
  output logic        tgtSck,
  output logic        tgtMosi,
  input  logic        tgtMiso
);

  localparam int DIV_W = (SCK_HALF < 2) ? 1 : $clog2(SCK_HALF);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_HALF - 1);

  logic [DIV_W-1:0]  divCnt;
  logic [4:0]        bitIdx;
  logic              active;
  logic              sckQ;
  logic              rstQ;
  logic              doneQ;
  logic [31:0]       txSh;
  logic [31:0]       rxSh;
  logic [WAIT_W-1:0] waitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      bitIdx  <= '0;
      active  <= 1'b0;
      sckQ    <= 1'b0;
      rstQ    <= 1'b0;
      doneQ   <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
      waitCnt <= '0;
    end else begin
      doneQ <= 1'b0;
      if (ctl.rstHigh)     rstQ <= 1'b1;
      else if (ctl.rstLow) rstQ <= 1'b0;

      if (ctl.waitGo)        waitCnt <= ctl.waitLen;
      else if (waitCnt != 0) waitCnt <= waitCnt - 1'b1;

      if (ctl.frameGo) begin
        active <= 1'b1;
        txSh   <= ctl.frame;
        bitIdx <= '0;
        divCnt <= '0;
        sckQ   <= 1'b0;
      end else if (active) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!sckQ) begin
            sckQ <= 1'b1;
            rxSh <= {rxSh[30:0], tgtMiso};
          end else begin
            sckQ <= 1'b0;
            if (bitIdx == 5'd31) begin
              active <= 1'b0;
              doneQ  <= 1'b1;
            end else begin
              bitIdx <= bitIdx + 1'b1;
              txSh   <= {txSh[30:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign frameDone = doneQ;
  assign rxLow     = rxSh[15:0];
  assign timerZero = (waitCnt == '0);
  assign tgtReset  = rstQ;
  assign tgtSck    = sckQ;
  assign tgtMosi   = txSh[31];

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sckQ && $past(sckQ)) |-> $stable(txSh[31])); // R3
  AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !sckQ); // R3
  AST_RESET_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    rstQ |-> !sckQ); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R4

endmodule

// File: rtl/serprog_ctrl.sv
module serprog_ctrl
  import serprog_pkg::*;
#(
  parameter int RST_CLKS    = 16,
  parameter int SETTLE_CLKS = 2500000,
  parameter int FLASH_WAIT  = 562500,
  parameter int EE_WAIT     = 1125000,
  parameter int MAX_TRY     = 8,
  parameter int PAGE_BITS   = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqCmd,
  input  logic [15:0] reqAddr,
  input  logic        reqHigh,
  input  logic [7:0]  reqData,
  input  logic        frameDone,
  input  logic [15:0] rxLow,
  input  logic        timerZero,
  output strobe_t     ctl,
  output logic        busy,
  output logic        enabled,
  output logic        errFlag,
  output logic        rdValid,
  output logic [7:0]  rdData
);

  localparam int TRY_W = $clog2(MAX_TRY + 1);
  localparam logic [7:0] PAGE_MASK = 8'((1 << PAGE_BITS) - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_SETTLE, S_ENFRAME, S_OPFRAME, S_OPWAIT
  } state_e;

  state_e     state, nextState;
  cmd_e       curCmd;
  logic [TRY_W-1:0] tries;
  logic [31:0] opFrame;
  logic        echoOk;
  logic        lastTry;
  logic        isMemCmd;

  assign echoOk   = (rxLow[15:8] == ECHO_KEY);
  assign lastTry  = (tries == TRY_W'(MAX_TRY - 1));
  assign isMemCmd = (reqCmd >= 3'd1) && (reqCmd <= 3'd5);

  always_comb begin
    case (cmd_e'(reqCmd))
      CMD_LOAD:   opFrame = {reqHigh ? OP_LOAD_HI : OP_LOAD_LO, 8'h00,
                             reqAddr[7:0] & PAGE_MASK, reqData};
      CMD_COMMIT: opFrame = {OP_COMMIT, reqAddr[15:8],
                             reqAddr[7:0] & ~PAGE_MASK, 8'h00};
      CMD_EEWR:   opFrame = {OP_EE_WR, reqAddr, reqData};
      CMD_FRD:    opFrame = {reqHigh ? OP_RD_HI : OP_RD_LO, reqAddr, 8'h00};
      default:    opFrame = {OP_EE_RD, reqAddr, 8'h00};
    endcase
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (reqValid) begin
        if (cmd_e'(reqCmd) == CMD_START) begin
          ctl.rstHigh = 1'b1;
          ctl.waitGo  = 1'b1;
          ctl.waitLen = WAIT_W'(RST_CLKS);
          nextState   = S_RST;
        end else if (cmd_e'(reqCmd) == CMD_RELEASE) begin
          ctl.rstHigh = 1'b1;
        end else if (isMemCmd && enabled) begin
          ctl.frameGo = 1'b1;
          ctl.frame   = opFrame;
          nextState   = S_OPFRAME;
        end
      end
      S_RST: if (timerZero) begin
        ctl.rstLow  = 1'b1;
        ctl.waitGo  = 1'b1;
        ctl.waitLen = WAIT_W'(SETTLE_CLKS);
        nextState   = S_SETTLE;
      end
      S_SETTLE: if (timerZero) begin
        ctl.frameGo = 1'b1;
        ctl.frame   = {OP_ENABLE, ECHO_KEY, 16'h0000};
        nextState   = S_ENFRAME;
      end
      S_ENFRAME: if (frameDone) begin
        if (echoOk || lastTry) begin
          nextState = S_IDLE;
        end else begin
          ctl.rstHigh = 1'b1;
          ctl.waitGo  = 1'b1;
          ctl.waitLen = WAIT_W'(RST_CLKS);
          nextState   = S_RST;
        end
      end
      S_OPFRAME: if (frameDone) begin
        if (curCmd == CMD_COMMIT) begin
          ctl.waitGo  = 1'b1;
          ctl.waitLen = WAIT_W'(FLASH_WAIT);
          nextState   = S_OPWAIT;
        end else if (curCmd == CMD_EEWR) begin
          ctl.waitGo  = 1'b1;
          ctl.waitLen = WAIT_W'(EE_WAIT);
          nextState   = S_OPWAIT;
        end else begin
          nextState = S_IDLE;
        end
      end
      S_OPWAIT: if (timerZero) nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curCmd  <= CMD_NONE;
      tries   <= '0;
      enabled <= 1'b0;
      errFlag <= 1'b0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      state   <= nextState;
      rdValid <= 1'b0;
      if (state == S_IDLE && reqValid) begin
        curCmd <= cmd_e'(reqCmd);
        if (cmd_e'(reqCmd) == CMD_START) begin
          tries   <= '0;
          errFlag <= 1'b0;
          enabled <= 1'b0;
        end else if (cmd_e'(reqCmd) == CMD_RELEASE) begin
          enabled <= 1'b0;
        end
      end
      if (state == S_ENFRAME && frameDone) begin
        if (echoOk)       enabled <= 1'b1;
        else if (lastTry) errFlag <= 1'b1;
        else              tries   <= tries + 1'b1;
      end
      if (state == S_OPFRAME && frameDone &&
          (curCmd == CMD_FRD || curCmd == CMD_EERD)) begin
        rdValid <= 1'b1;
        rdData  <= rxLow[7:0];
      end
    end
  end

  assign busy = (state != S_IDLE);

  AST_ERR_EXCLUDES_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !enabled); // R5
  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    tries < TRY_W'(MAX_TRY)); // R5
  AST_FRAME_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.frameGo && state == S_IDLE) |-> enabled); // R10
  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R9

endmodule

// File: rtl/serprog_host.sv
module serprog_host
  import serprog_pkg::*;
#(
  parameter int SCK_HALF    = 4,
  parameter int RST_CLKS    = 16,
  parameter int SETTLE_CLKS = 2500000,
  parameter int FLASH_WAIT  = 562500,
  parameter int EE_WAIT     = 1125000,
  parameter int MAX_TRY     = 8,
  parameter int PAGE_BITS   = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqCmd,
  input  logic [15:0] reqAddr,
  input  logic        reqHigh,
  input  logic [7:0]  reqData,
  output logic        busy,
  output logic        enabled,
  output logic        errFlag,
  output logic        rdValid,
  output logic [7:0]  rdData,
  output logic        tgtReset,
  output logic        tgtSck,
  output logic        tgtMosi,
  input  logic        tgtMiso
);

  strobe_t     ctl;
  logic        frameDone;
  logic [15:0] rxLow;
  logic        timerZero;

  serprog_ctrl #(
    .RST_CLKS(RST_CLKS), .SETTLE_CLKS(SETTLE_CLKS), .FLASH_WAIT(FLASH_WAIT),
    .EE_WAIT(EE_WAIT), .MAX_TRY(MAX_TRY), .PAGE_BITS(PAGE_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqHigh(reqHigh), .reqData(reqData),
    .frameDone(frameDone), .rxLow(rxLow), .timerZero(timerZero),
    .ctl(ctl), .busy(busy), .enabled(enabled), .errFlag(errFlag),
    .rdValid(rdValid), .rdData(rdData)
  );

  serprog_dp #(.SCK_HALF(SCK_HALF)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .frameDone(frameDone), .rxLow(rxLow),
    .timerZero(timerZero), .tgtReset(tgtReset), .tgtSck(tgtSck),
    .tgtMosi(tgtMosi), .tgtMiso(tgtMiso)
  );

endmodule

// File: tb/serprog_host_bench.sv
`timescale 1ns/1ps
module serprog_host_bench;

  localparam int HALF = 2;
  localparam int RSTC = 4;
  localparam int SETL = 50;
  localparam int FW   = 100;
  localparam int EW   = 60;
  localparam int TRY  = 8;
  localparam int FRAME_CLKS = 64 * HALF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqCmd = 3'd7;
  logic [15:0] reqAddr = '0;
  logic reqHigh = 1'b0;
  logic [7:0] reqData = '0;
  logic busy, enabled, errFlag, rdValid;
  logic [7:0] rdData;
  logic tgtReset, tgtSck, tgtMosi;
  logic tgtMiso = 1'b0;

  always #4 clk = ~clk;

  serprog_host #(
    .SCK_HALF(HALF), .RST_CLKS(RSTC), .SETTLE_CLKS(SETL), .FLASH_WAIT(FW),
    .EE_WAIT(EW), .MAX_TRY(TRY), .PAGE_BITS(6)
  ) u_serprog_host (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd),
    .reqAddr(reqAddr), .reqHigh(reqHigh), .reqData(reqData), .busy(busy),
    .enabled(enabled), .errFlag(errFlag), .rdValid(rdValid), .rdData(rdData),
    .tgtReset(tgtReset), .tgtSck(tgtSck), .tgtMosi(tgtMosi), .tgtMiso(tgtMiso)
  );

  int nChecks = 0;
  int nFail = 0;

  // ---------------- pin monitor (negedge sampling) ----------------
  int cyc = 0;
  logic prevSck = 1'b0, prevRst = 1'b0;
  int runLen = 0, phaseErr = 0, sckRises = 0, rstPulses = 0;
  int rstStart = 0, rstWidthMin = 1000000, fallCyc = 0, settleMin = 1000000;
  bit settleArmed = 1'b0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (tgtSck != prevSck) begin
        if (prevSck && runLen != HALF) phaseErr <= phaseErr + 1;
        if (!prevSck && runLen < HALF) phaseErr <= phaseErr + 1;
        if (tgtSck) begin
          sckRises <= sckRises + 1;
          if (settleArmed) begin
            if (cyc - fallCyc < settleMin) settleMin <= cyc - fallCyc;
            settleArmed <= 1'b0;
          end
        end
        runLen <= 1;
      end else begin
        runLen <= runLen + 1;
      end
      if (tgtReset && !prevRst) begin
        rstPulses <= rstPulses + 1;
        rstStart  <= cyc;
      end
      if (!tgtReset && prevRst) begin
        if (cyc - rstStart < rstWidthMin) rstWidthMin <= cyc - rstStart;
        fallCyc     <= cyc;
        settleArmed <= 1'b1;
      end
      prevSck <= tgtSck;
      prevRst <= tgtReset;
    end
  end

  // ---------------- target model ----------------
  logic [15:0] flashMem [0:1023];
  logic [7:0]  eeMem [0:255];
  logic [7:0]  pageLo [0:63];
  logic [7:0]  pageHi [0:63];
  logic [31:0] rxSh = '0;
  logic [7:0]  outByte = '0;
  int bitCnt = 0, enFrames = 0, badUntil = 0;
  int lastWrCyc = -1000000, needWait = 0, delayViol = 0;

  initial begin
    for (int i = 0; i < 1024; i++) flashMem[i] = 16'hFFFF;
    for (int i = 0; i < 256; i++) eeMem[i] = 8'hFF;
    for (int i = 0; i < 64; i++) begin pageLo[i] = 8'hFF; pageHi[i] = 8'hFF; end
  end

  always @(posedge tgtSck) begin
    logic [9:0] base;
    logic [15:0] w;
    if (!tgtReset) begin
      rxSh = {rxSh[30:0], tgtMosi};
      bitCnt = bitCnt + 1;
      if (bitCnt % 32 == 1 && cyc - lastWrCyc < needWait) delayViol = delayViol + 1;
      if (bitCnt % 8 == 0) begin
        case ((bitCnt / 8) % 4)
          1: outByte = rxSh[7:0];
          2: outByte = (rxSh[15:8] == 8'hAC && enFrames < badUntil) ? 8'h00 : rxSh[7:0];
          3: begin
            w = flashMem[{rxSh[9:8], rxSh[7:0]}];
            case (rxSh[23:16])
              8'h20:   outByte = w[7:0];
              8'h28:   outByte = w[15:8];
              8'hA0:   outByte = eeMem[rxSh[7:0]];
              default: outByte = rxSh[7:0];
            endcase
          end
          default: begin
            outByte = 8'h00;
            case (rxSh[31:24])
              8'hAC: enFrames = enFrames + 1;
              8'h40: pageLo[rxSh[13:8]] = rxSh[7:0];
              8'h48: pageHi[rxSh[13:8]] = rxSh[7:0];
              8'h4C: begin
                base = {rxSh[17:16], rxSh[15:8]} & 10'h3C0;
                for (int i = 0; i < 64; i++) flashMem[base + 10'(i)] = {pageHi[i], pageLo[i]};
                lastWrCyc = cyc; needWait = FW;
              end
              8'hC0: begin
                eeMem[rxSh[15:8]] = rxSh[7:0];
                lastWrCyc = cyc; needWait = EW;
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always @(negedge tgtSck) tgtMiso <= outByte[7 - (bitCnt % 8)];

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [15:0] a, input logic h, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqCmd = c; reqAddr = a; reqHigh = h; reqData = d;
    @(negedge clk);
    reqValid = 1'b0; reqCmd = 3'd7;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 60000) begin @(negedge clk); n++; end
  endtask

  function automatic logic [7:0] patLo(input int i); return 8'((i * 37 + 5) & 255); endfunction
  function automatic logic [7:0] patHi(input int i); return 8'(i) ^ 8'hA5; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks + 1, nFail + 1);
    $finish;
  end

  initial begin
    int n, r0, f0, e0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({tgtReset, tgtSck, busy, enabled, errFlag} == 5'b0, "R1", {tgtReset, tgtSck, busy, enabled, errFlag}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10 memory command before enable
    r0 = sckRises;
    issue(3'd4, 16'h0040, 1'b0, 8'h00);
    repeat (10) @(negedge clk);
    chk(!busy && sckRises == r0, "R10", sckRises - r0, 0);

    // R4/R5 enable with three spoiled echoes
    badUntil = enFrames + 3;
    f0 = rstPulses; e0 = enFrames;
    issue(3'd0, 16'h0, 1'b0, 8'h0);
    waitIdle(n);
    chk(enabled && !errFlag, "R4", {enabled, errFlag}, 2);
    chk(enFrames - e0 == 4, "R4", enFrames - e0, 4);
    chk(rstPulses - f0 == 4, "R5", rstPulses - f0, 4);
    chk(rstWidthMin >= RSTC, "R2", rstWidthMin, RSTC);
    chk(settleMin >= SETL, "R2", settleMin, SETL);

    // R6 page load, low byte before high byte for each word
    for (int i = 0; i < 64; i++) begin
      issue(3'd1, 16'h0040 + 16'(i), 1'b0, patLo(i));
      waitIdle(n);
      if (i == 0) chk(n <= FRAME_CLKS + 4, "R6", n, FRAME_CLKS);
      issue(3'd1, 16'h0040 + 16'(i), 1'b1, patHi(i));
      waitIdle(n);
    end
    // R7 commit with non-zero offset bits
    issue(3'd2, 16'h0045, 1'b0, 8'h00);
    waitIdle(n);
    chk(n >= FRAME_CLKS + FW, "R7", n, FRAME_CLKS + FW);

    // R9 read back whole page
    for (int i = 0; i < 64; i++) begin
      issue(3'd4, 16'h0040 + 16'(i), 1'b0, 8'h00);
      waitIdle(n);
      chk(rdData == patLo(i), "R9 R6 flash low", rdData, patLo(i));
      issue(3'd4, 16'h0040 + 16'(i), 1'b1, 8'h00);
      waitIdle(n);
      chk(rdData == patHi(i), "R9 R6 flash high", rdData, patHi(i));
    end
    issue(3'd4, 16'h0080, 1'b0, 8'h00);
    waitIdle(n);
    chk(rdData == 8'hFF, "R7 outside page", rdData, 8'hFF);

    // R8 EEPROM writes and reads
    for (int i = 0; i < 16; i++) begin
      issue(3'd3, 16'h0010 + 16'(i), 1'b0, 8'((i * 29 + 3) & 255));
      waitIdle(n);
      if (i == 0) chk(n >= FRAME_CLKS + EW, "R8 delay", n, FRAME_CLKS + EW);
    end
    for (int i = 0; i < 16; i++) begin
      issue(3'd5, 16'h0010 + 16'(i), 1'b0, 8'h00);
      waitIdle(n);
      chk(rdData == 8'((i * 29 + 3) & 255), "R8 R9 eeprom", rdData, (i * 29 + 3) & 255);
    end
    chk(delayViol == 0, "R7 R8 write delay", delayViol, 0);

    // R10 command 7 while enabled
    r0 = sckRises;
    issue(3'd7, 16'h0, 1'b0, 8'h0);
    repeat (10) @(negedge clk);
    chk(!busy && sckRises == r0, "R10", sckRises - r0, 0);

    // R5 retries exhausted
    badUntil = enFrames + 20;
    f0 = rstPulses; e0 = enFrames;
    issue(3'd0, 16'h0, 1'b0, 8'h0);
    waitIdle(n);
    chk(errFlag && !enabled && !busy, "R5", {errFlag, enabled, busy}, 4);
    chk(rstPulses - f0 == TRY, "R5", rstPulses - f0, TRY);
    chk(enFrames - e0 == TRY, "R4", enFrames - e0, TRY);

    // R11 release
    issue(3'd6, 16'h0, 1'b0, 8'h0);
    repeat (3) @(negedge clk);
    chk(tgtReset && !enabled, "R11", {tgtReset, enabled}, 2);
    r0 = sckRises;
    issue(3'd5, 16'h0010, 1'b0, 8'h0);
    repeat (10) @(negedge clk);
    chk(!busy && sckRises == r0, "R10", sckRises - r0, 0);

    chk(phaseErr == 0, "R3", phaseErr, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule